// File: doc/BRIEF.md
# ADC Conversion Control Register Block

This block is the software-facing front end of a two-engine analog-to-digital converter. Engine 0 measures an auxiliary input and engine 1 measures a battery input. A processor reaches it through a small memory-mapped register port with per-byte write enables. Software starts a conversion by setting that engine's bit in the start register. The block then asks an external converter for one sample over a request/acknowledge handshake, stores the returned code in that engine's result register, and clears the start bit. Software learns that the result is ready by polling for the bit to fall back to zero.

When both engine bits are pending, the block serves them one at a time, auxiliary first. Software may withdraw a pending or running request by writing its bit back to zero. A configuration register carries a battery range select bit, which is captured at the start of each conversion and sent to the converter. A sticky per-engine completion flag sits in a status register, and a mask register can suppress that flag for each engine.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero: start (0x00), configuration (0x04), mask (0x08), status (0x0C), battery result (0x1C) and auxiliary result (0x20). conv_req is low.
- R2: Writing 1 to bit i of byte lane 0 at offset 0x00 starts a conversion on engine i (0 = auxiliary, 1 = battery). conv_req rises with conv_eng = i. It stays high with conv_eng unchanged until conv_ack, unless software withdraws the request.
- R3: When conv_ack arrives, conv_code is stored zero-extended in that engine's result register: bits [11:0] of 0x20 for auxiliary, bits [11:0] of 0x1C for battery, with the upper bits zero. The engine's start bit then reads 0.
- R4: A result register changes only when a conversion on its own engine completes. The other engine's completion or a withdrawn request leaves it unchanged.
- R5: If both start bits are set together, the auxiliary conversion runs first and the battery conversion runs second. Each bit clears on its own, so the start register reads 0x02 between the two completions.
- R6: Writing 0 to a running engine's start bit withdraws the request. conv_req drops by the next cycle, and neither the result register nor the status flag changes.
- R7: conv_low_range equals configuration bit 4 as it was when the conversion started. Writing the configuration register during a conversion does not change conv_low_range for that conversion.
- R8: Configuration writes change only the byte lanes whose bus_be bit is set. All other bits keep their values.
- R9: Status bit i is set when engine i completes, unless mask bit i (offset 0x08) is 1. The flag stays set until a write of 1 to status bit i in lane 0 clears it. Writing 0 leaves it unchanged.
- R10: The mask register is eight bits wide in lane 0 of 0x08 and reads back what was written, including 0xFF.
- R11: Unmapped offsets read zero. Start-register bits above the engine count read zero, and writing them starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 6 | Byte offset of the word accessed |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| conv_req | output | 1 | Conversion request to the converter |
| conv_eng | output | 1 | Engine being converted (0 auxiliary, 1 battery) |
| conv_low_range | output | 1 | Battery low range select captured at start |
| conv_ack | input | 1 | One-cycle conversion done from the converter |
| conv_code | input | 12 | Conversion code, valid with conv_ack |

## Verification
The bench builds the block with its default parameters: two engines, 12-bit codes and the range bit at position 4. A converter stub with adjustable latency answers requests. Short latencies let the bench catch the start register passing through 0x02 between the two conversions of a dual start. A very long latency keeps a request open so that withdrawal can be tested without a competing acknowledge. Full-scale and near-zero codes check the zero extension into the 16-bit result registers. A scoreboard queue records the engine order and range bit expected at each acknowledge.

// File: rtl/adc_regs_pkg.sv
// Shared constants for the ADC conversion control block.
// Assumes a 6-bit byte offset and word-aligned registers.
package adc_regs_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFF_START = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_CFG   = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_MASK  = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_BATD  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_AUXD  = 6'h20;

    localparam int ENG_AUX = 0;
    localparam int ENG_BAT = 1;

    typedef enum logic [0:0] {SEQ_IDLE = 1'b0, SEQ_BUSY = 1'b1} seq_state_t;
endpackage

// File: rtl/adc_seq.sv
// Start bits and conversion sequencer.
// Holds one software-set, hardware-cleared start bit per engine. It serves
// pending engines one at a time, lowest index first, over a level request
// and a one-cycle acknowledge. A cleared start bit withdraws its request.
// Assumes the converter may be abandoned by dropping conv_req.
module adc_seq
    import adc_regs_pkg::*;
#(
    parameter int NUM_ENG = 2,
    parameter int CODE_W  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_wr,
    input  logic [NUM_ENG-1:0]         en_wdata,
    input  logic                       range_sel,
    input  logic                       conv_ack,
    output logic [NUM_ENG-1:0]         en_bits,
    output logic [NUM_ENG-1:0]         done,
    output logic                       conv_req,
    output logic [$clog2(NUM_ENG)-1:0] conv_eng,
    output logic                       conv_low_range
);
    localparam int ENG_W = $clog2(NUM_ENG);

    seq_state_t       state_q;
    logic [ENG_W-1:0] cur_q;
    logic             low_q;
    logic [ENG_W-1:0] pick;
    logic             cur_live;
    logic             complete;

    // Lowest-index pending engine wins.
    always_comb begin
        pick = '0;
        for (int i = NUM_ENG - 1; i >= 0; i--) begin
            if (en_bits[i]) pick = ENG_W'(i);
        end
    end

    assign cur_live = en_bits[cur_q];
    assign complete = (state_q == SEQ_BUSY) && cur_live && conv_ack;

    // One-hot completion pulse for the engine that finished.
    always_comb begin
        done = '0;
        if (complete) done[cur_q] = 1'b1;
    end

    // Start bits: software write, then hardware clear on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_bits <= '0;
        end else begin
            logic [NUM_ENG-1:0] nxt;
            nxt = en_wr ? en_wdata : en_bits;
            if (complete) nxt[cur_q] = 1'b0;
            en_bits <= nxt;
        end
    end

    // Sequencer: pick an engine, capture the range, wait for ack or withdrawal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
            low_q   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (|en_bits) begin
                        state_q <= SEQ_BUSY;
                        cur_q   <= pick;
                        low_q   <= range_sel;
                    end
                end
                default: begin
                    if (!cur_live || conv_ack) state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

    assign conv_req       = (state_q == SEQ_BUSY) && cur_live;
    assign conv_eng       = cur_q;
    assign conv_low_range = low_q;

    // R2: an open request holds its engine until acknowledged or withdrawn.
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_ack && !en_wr |=> conv_req && $stable(conv_eng));

    // R3: a completed engine's start bit reads zero afterwards.
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> ((en_bits & $past(done)) == '0));

    // R5: a new request serves engine 0 whenever it was pending.
    a_r5_aux_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_req) && $past(en_bits[0]) && $past(!conv_req) |-> conv_eng == '0);

    // R6: clearing the running engine's bit drops the request.
    a_r6_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && en_wr && !en_wdata[conv_eng] |=> !conv_req);

    // R7: the range select is frozen while a request is open.
    a_r7_range_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && $past(conv_req) |-> $stable(conv_low_range));
endmodule

// File: rtl/adc_reg_file.sv
// Register file and bus decode for the ADC conversion control block.
// Holds the configuration, mask, sticky status and per-engine result
// registers, and drives the combinational read mux. Assumes single-cycle
// writes with per-lane enables and reads taken from the whole word.
module adc_reg_file
    import adc_regs_pkg::*;
#(
    parameter int NUM_ENG   = 2,
    parameter int CODE_W    = 12,
    parameter int RANGE_BIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [3:0]         bus_be,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic [NUM_ENG-1:0] en_bits,
    input  logic [NUM_ENG-1:0] done,
    input  logic [CODE_W-1:0]  done_code,
    output logic               en_wr,
    output logic [NUM_ENG-1:0] en_wdata,
    output logic               range_sel
);
    logic [BUS_W-1:0]   cfg_q;
    logic [7:0]         mask_q;
    logic [NUM_ENG-1:0] stat_q;
    logic [DATA_W-1:0]  data_q [NUM_ENG];
    logic               hit_cfg;
    logic               hit_mask;
    logic               hit_stat;

    assign en_wr    = bus_wr && (bus_addr == OFF_START) && bus_be[0];
    assign en_wdata = bus_wdata[NUM_ENG-1:0];
    assign hit_cfg  = bus_wr && (bus_addr == OFF_CFG);
    assign hit_mask = bus_wr && (bus_addr == OFF_MASK) && bus_be[0];
    assign hit_stat = bus_wr && (bus_addr == OFF_STAT) && bus_be[0];
    assign range_sel = cfg_q[RANGE_BIT];

    // Configuration register: one flop group per byte lane.
    for (genvar k = 0; k < 4; k++) begin : g_cfg_lane
        always_ff @(posedge clk) begin
            if (!rst_n)                  cfg_q[k*8 +: 8] <= 8'h00;
            else if (hit_cfg && bus_be[k]) cfg_q[k*8 +: 8] <= bus_wdata[k*8 +: 8];
        end
    end

    // Event mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= 8'h00;
        else if (hit_mask) mask_q <= bus_wdata[7:0];
    end

    // Sticky done flags: write-one-to-clear, an unmasked completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            logic [NUM_ENG-1:0] clr;
            clr    = hit_stat ? bus_wdata[NUM_ENG-1:0] : '0;
            stat_q <= (stat_q & ~clr) | (done & ~mask_q[NUM_ENG-1:0]);
        end
    end

    // Per-engine result registers, loaded only on their own completion.
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_data
        always_ff @(posedge clk) begin
            if (!rst_n)       data_q[e] <= '0;
            else if (done[e]) data_q[e] <= {{(DATA_W-CODE_W){1'b0}}, done_code};
        end

        // R4: a result register is untouched without its own completion.
        a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !done[e] |=> $stable(data_q[e]));

        // R9: an unmasked completion leaves its flag set.
        a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
            done[e] && !mask_q[e] |=> stat_q[e]);

        // R9: a masked completion does not raise a clear flag.
        a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
            done[e] && mask_q[e] && !stat_q[e] |=> !stat_q[e]);
    end

    // Read mux by offset; unmapped offsets read zero.
    always_comb begin
        case (bus_addr)
            OFF_START: bus_rdata = {{(BUS_W-NUM_ENG){1'b0}}, en_bits};
            OFF_CFG:   bus_rdata = cfg_q;
            OFF_MASK:  bus_rdata = {{(BUS_W-8){1'b0}}, mask_q};
            OFF_STAT:  bus_rdata = {{(BUS_W-NUM_ENG){1'b0}}, stat_q};
            OFF_BATD:  bus_rdata = {{(BUS_W-DATA_W){1'b0}}, data_q[ENG_BAT]};
            OFF_AUXD:  bus_rdata = {{(BUS_W-DATA_W){1'b0}}, data_q[ENG_AUX]};
            default:   bus_rdata = '0;
        endcase
    end

    // R8: lanes without a byte enable keep their configuration bits.
    a_r8_lane_keep: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cfg && !bus_be[1] |=> $stable(cfg_q[15:8]));
endmodule

// File: rtl/adc_ctrl_regs.sv
// Top of the ADC conversion control block: a register port in front of the
// start/done sequencer and a converter handshake. The code bus is
// assumed valid whenever conv_ack is high.
module adc_ctrl_regs
    import adc_regs_pkg::*;
#(
    parameter int NUM_ENG   = 2,
    parameter int CODE_W    = 12,
    parameter int RANGE_BIT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [3:0]                 bus_be,
    input  logic [BUS_W-1:0]           bus_wdata,
    output logic [BUS_W-1:0]           bus_rdata,
    output logic                       conv_req,
    output logic [$clog2(NUM_ENG)-1:0] conv_eng,
    output logic                       conv_low_range,
    input  logic                       conv_ack,
    input  logic [CODE_W-1:0]          conv_code
);
    logic               en_wr;
    logic [NUM_ENG-1:0] en_wdata;
    logic [NUM_ENG-1:0] en_bits;
    logic [NUM_ENG-1:0] done;
    logic               range_sel;

    adc_seq #(.NUM_ENG(NUM_ENG), .CODE_W(CODE_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .en_wr          (en_wr),
        .en_wdata       (en_wdata),
        .range_sel      (range_sel),
        .conv_ack       (conv_ack),
        .en_bits        (en_bits),
        .done           (done),
        .conv_req       (conv_req),
        .conv_eng       (conv_eng),
        .conv_low_range (conv_low_range)
    );

    adc_reg_file #(.NUM_ENG(NUM_ENG), .CODE_W(CODE_W), .RANGE_BIT(RANGE_BIT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_bits   (en_bits),
        .done      (done),
        .done_code (conv_code),
        .en_wr     (en_wr),
        .en_wdata  (en_wdata),
        .range_sel (range_sel)
    );

    // R1: no request is open in the cycle after reset.
    a_r1_quiet_reset: assert property (@(posedge clk)
        !rst_n |=> !conv_req);
endmodule

// File: tb/tb_adc_ctrl_regs.sv
// Scoreboard bench: start tasks queue the expected {engine, range} per
// conversion, and a monitor pops one entry at each acknowledge.
module tb_adc_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_req;
    logic [0:0]  conv_eng;
    logic        conv_low_range;
    logic        conv_ack = 1'b0;
    logic [11:0] conv_code = '0;

    int          total = 0;
    int          bad = 0;
    int          lat = 4;
    int          scnt = 0;
    logic [11:0] stub_code [2];
    logic [1:0]  exp_q [$];
    logic [31:0] cfg_model = '0;
    logic [31:0] rv;

    adc_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_req(conv_req), .conv_eng(conv_eng), .conv_low_range(conv_low_range),
        .conv_ack(conv_ack), .conv_code(conv_code)
    );

    always #2.5 clk = ~clk;

    // Converter stub: acknowledges after lat cycles of an open request.
    always @(posedge clk) begin
        if (!rst_n) begin
            scnt <= 0; conv_ack <= 1'b0;
        end else if (conv_ack) begin
            conv_ack <= 1'b0; scnt <= 0;
        end else if (conv_req) begin
            if (scnt >= lat) begin
                conv_ack  <= 1'b1;
                conv_code <= stub_code[conv_eng];
            end else begin
                scnt <= scnt + 1;
            end
        end else begin
            scnt <= 0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: each acknowledge must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && conv_req && conv_ack) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected conversion", {31'd0, conv_eng}, 32'hFFFF_FFFF);
            end else begin
                logic [1:0] it;
                it = exp_q.pop_front();
                chk("R5 engine order", {31'd0, conv_eng}, {31'd0, it[1]});
                chk("R7 range at start", {31'd0, conv_low_range}, {31'd0, it[0]});
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic start(input logic [1:0] m);
        if (m[0]) exp_q.push_back({1'b0, cfg_model[4]});
        if (m[1]) exp_q.push_back({1'b1, cfg_model[4]});
        wr(6'h00, 4'b0001, {30'd0, m});
    endtask

    task automatic wait_clear();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd(6'h00, v);
            if (v == 0) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        stub_code[0] = '0; stub_code[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(6'h00, rv); chk("R1 start", rv, 0);
        rd(6'h04, rv); chk("R1 cfg", rv, 0);
        rd(6'h08, rv); chk("R1 mask", rv, 0);
        rd(6'h0C, rv); chk("R1 status", rv, 0);
        rd(6'h1C, rv); chk("R1 battery data", rv, 0);
        rd(6'h20, rv); chk("R1 aux data", rv, 0);
        chk("R1 conv_req", {31'd0, conv_req}, 0);

        // R2 R3 auxiliary conversion
        lat = 6; stub_code[0] = 12'hABC;
        start(2'b01);
        @(negedge clk);
        chk("R2 request", {30'd0, conv_req, conv_eng}, 32'h2);
        wait_clear();
        rd(6'h20, rv); chk("R3 aux data", rv, 32'h0ABC);
        rd(6'h00, rv); chk("R3 start cleared", rv, 0);

        // R3 R4 battery in low range with full-scale code
        wr(6'h04, 4'b0001, 32'h10); cfg_model = 32'h10;
        stub_code[1] = 12'hFFF;
        start(2'b10);
        wait_clear();
        rd(6'h1C, rv); chk("R3 battery data", rv, 32'h0FFF);
        rd(6'h20, rv); chk("R4 aux kept", rv, 32'h0ABC);

        // R7 range captured at start
        lat = 10; stub_code[1] = 12'h123;
        start(2'b10);
        @(negedge clk);
        wr(6'h04, 4'b0001, 32'h00); cfg_model = 32'h0;
        @(negedge clk);
        chk("R7 range held", {31'd0, conv_low_range}, 1);
        wait_clear();
        rd(6'h1C, rv); chk("R3 battery data 2", rv, 32'h0123);

        // R5 both engines
        lat = 5; stub_code[0] = 12'h001; stub_code[1] = 12'h7E5;
        start(2'b11);
        for (int i = 0; i < 100; i++) begin
            rd(6'h00, rv);
            if (rv != 32'h3) break;
            @(negedge clk);
        end
        chk("R5 aux cleared first", rv, 32'h2);
        wait_clear();
        rd(6'h20, rv); chk("R5 aux data", rv, 32'h0001);
        rd(6'h1C, rv); chk("R5 battery data", rv, 32'h07E5);

        // R9 status flags, R10 mask register
        rd(6'h0C, rv); chk("R9 both flags", rv, 32'h3);
        wr(6'h0C, 4'b0001, 32'h1);
        rd(6'h0C, rv); chk("R9 w1c aux", rv, 32'h2);
        wr(6'h0C, 4'b0001, 32'h0);
        rd(6'h0C, rv); chk("R9 write zero keeps", rv, 32'h2);
        wr(6'h0C, 4'b0001, 32'h2);
        rd(6'h0C, rv); chk("R9 w1c battery", rv, 32'h0);
        wr(6'h08, 4'b0001, 32'h2);
        stub_code[1] = 12'h456;
        start(2'b10);
        wait_clear();
        rd(6'h0C, rv); chk("R9 masked battery", rv, 32'h0);
        rd(6'h1C, rv); chk("R9 masked data", rv, 32'h0456);
        stub_code[0] = 12'h321;
        start(2'b01);
        wait_clear();
        rd(6'h0C, rv); chk("R9 unmasked aux", rv, 32'h1);
        wr(6'h08, 4'b0001, 32'hFF);
        rd(6'h08, rv); chk("R10 mask readback", rv, 32'hFF);
        wr(6'h08, 4'b0001, 32'h00);
        wr(6'h0C, 4'b0001, 32'h3);

        // R6 withdraw a running battery conversion
        lat = 1000; stub_code[1] = 12'h9AB;
        wr(6'h00, 4'b0001, 32'h2);
        repeat (3) @(negedge clk);
        chk("R6 running", {31'd0, conv_req}, 1);
        wr(6'h00, 4'b0001, 32'h0);
        @(negedge clk);
        chk("R6 request dropped", {31'd0, conv_req}, 0);
        rd(6'h00, rv); chk("R6 start zero", rv, 0);
        rd(6'h1C, rv); chk("R6 data kept", rv, 32'h0456);
        rd(6'h0C, rv); chk("R6 no flag", rv, 0);
        lat = 3; stub_code[0] = 12'h0DD;
        start(2'b01);
        wait_clear();
        rd(6'h20, rv); chk("R4 aux after withdraw", rv, 32'h00DD);
        rd(6'h1C, rv); chk("R4 battery after withdraw", rv, 32'h0456);

        // R8 byte-lane configuration writes
        wr(6'h04, 4'b1111, 32'hA5A5_5A5A);
        rd(6'h04, rv); chk("R8 full word", rv, 32'hA5A5_5A5A);
        wr(6'h04, 4'b0010, 32'h0000_FF00);
        rd(6'h04, rv); chk("R8 lane 1", rv, 32'hA5A5_FF5A);
        wr(6'h04, 4'b1100, 32'h1234_0000);
        rd(6'h04, rv); chk("R8 upper half", rv, 32'h1234_FF5A);

        // R11 unmapped offsets and non-engine start bits
        rd(6'h10, rv); chk("R11 offset 0x10", rv, 0);
        rd(6'h14, rv); chk("R11 offset 0x14", rv, 0);
        wr(6'h00, 4'b0001, 32'hFC);
        rd(6'h00, rv); chk("R11 high start bits", rv, 0);
        @(negedge clk);
        chk("R11 nothing started", {31'd0, conv_req}, 0);
        chk("R5 scoreboard drained", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule